// File: doc/BRIEF.md
# Serial Controller Interrupt Identification Unit

This unit decides which interrupt a 16550-style serial controller reports to its host. It holds the four-bit interrupt enable register and a hidden "transmitter ready" pending flag. Each cycle it compares the enable bits with live status inputs and picks one source by a fixed priority. The status inputs are line errors, data ready, receive FIFO fill against the trigger level, character timeout and modem-line deltas. It drives the identification byte that a host read returns, and a level interrupt line.

Register accesses reach the unit as single-cycle strobes from the surrounding register decoder:
- an enable-register write, which carries the written byte and the current transmit-holding-empty state;
- a transmit-holding write;
- an identification-register read.

The identification byte and the interrupt line are combinational functions of the registered state and the current inputs. A read strobe therefore sees the value from before the flag update that the read causes.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the stored enables are 0, the pending flag is clear, the identification low nibble reads 0x1 and `irqOut` is low.
- R2: Sources are ranked, highest first: line status (code 0x6), character timeout (0xC), received data (0x4), transmitter ready (0x2), modem status (0x0). The code appears in bits 3:0 of `iirValue`.
- R3: Line status is reported only when enable bit 2 is set and at least one of `lineStat[4:1]` (overrun, parity, framing, break) is 1.
- R4: Character timeout is reported only when enable bit 0 (receive data) is set and `rxTimeout` is high.
- R5: Received data needs enable bit 0 and data ready (`lineStat[0]`). When `fifoEnable` is high, it also needs `rxCount >= rxTrigLevel`.
- R6: If enable bit 0 and data ready are both set but the FIFO count is below the trigger level, neither transmitter ready nor modem status is reported. The code reads 0x1 unless a higher source is active.
- R7: Bits 7:6 of `iirValue` read 11 while `fifoEnable` is high and 00 otherwise. Bits 5:4 read 0. With no source active, the low nibble is 0x1.
- R8: An identification read clears the pending flag at the clock edge. The value presented during the read cycle is the value before the clear.
- R9: An enable write stores only `ierWrData[3:0]`, readable on `ierValue`. When `thrEmpty` is high during that write, the pending flag is set. Enable bit 1 gates transmitter ready and bit 3 gates modem status (any `msrDelta` bit).
- R10: A transmit-holding write clears the pending flag.
- R11: When a clearing access (identification read or transmit-holding write) coincides with an arming enable write, the flag ends up clear. The enable value is still stored.
- R12: `irqOut` is high exactly when the low nibble of `iirValue` differs from 0x1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ierWrEn | input | 1 | Enable-register write strobe |
| ierWrData | input | 8 | Byte written to the enable register |
| thrEmpty | input | 1 | Transmit holding register empty, sampled on enable writes |
| thrWrEn | input | 1 | Transmit-holding write strobe |
| iirRdEn | input | 1 | Identification-register read strobe |
| lineStat | input | 5 | Bit 0 data ready, bits 4:1 overrun/parity/framing/break |
| rxTimeout | input | 1 | Character timeout pending |
| fifoEnable | input | 1 | FIFO mode active |
| rxCount | input | CNT_W | Receive FIFO fill count |
| rxTrigLevel | input | CNT_W | Receive trigger level |
| msrDelta | input | 4 | Modem status change bits |
| iirValue | output | 8 | Identification byte |
| irqOut | output | 1 | Level interrupt request |
| ierValue | output | 4 | Stored enable bits |

## Verification
Two pending-flag functions can meet in one cycle. An enable write with `thrEmpty` high arms the flag. An identification read or a transmit-holding write clears it. The bench asserts both strobes in the same cycle. It then requires the transmitter-ready code to be absent on the next cycle while the new enable value is present on `ierValue`. A second overlap is also checked: the read itself must still show code 0x2 during its own cycle, before the clear takes effect.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    CODE_MODEM  = 4'h0,
    CODE_NONE   = 4'h1,
    CODE_TXRDY  = 4'h2,
    CODE_RXDATA = 4'h4,
    CODE_LINE   = 4'h6,
    CODE_TMOUT  = 4'hC
  } irqCode_e;

  // Enable-register bit positions
  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  typedef struct packed {
    logic loadIer;
    logic armPend;
    logic clearPend;
  } ctrlStrobes_t;

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic         ierWrEn,
  input  logic         thrEmpty,
  input  logic         thrWrEn,
  input  logic         iirRdEn,
  output ctrlStrobes_t strobe
);

  always_comb begin
    strobe.loadIer   = ierWrEn;
    strobe.armPend   = ierWrEn & thrEmpty;
    strobe.clearPend = thrWrEn | iirRdEn;
  end

endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobe,
  input  logic [7:0]       ierWrData,
  input  logic [4:0]       lineStat,
  input  logic             rxTimeout,
  input  logic             fifoEnable,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] rxTrigLevel,
  input  logic [3:0]       msrDelta,
  output logic [7:0]       iirValue,
  output logic             irqOut,
  output logic [3:0]       ierValue
);

  logic [3:0] ierReg;
  logic       txPend;
  logic       unusedHigh;
  irqCode_e   code;

  logic lineReq, tmoReq, rxGate, rxReady, txReq, modemReq;

  assign unusedHigh = ^ierWrData[7:4];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ierReg <= '0;
      txPend <= 1'b0;
    end else begin
      if (strobe.loadIer) ierReg <= ierWrData[3:0];
      if (strobe.clearPend)    txPend <= 1'b0;
      else if (strobe.armPend) txPend <= 1'b1;
    end
  end

  always_comb begin
    lineReq  = ierReg[EN_LINE] & (|lineStat[4:1]);
    tmoReq   = ierReg[EN_RX] & rxTimeout;
    rxGate   = ierReg[EN_RX] & lineStat[0];
    rxReady  = rxGate & (~fifoEnable | (rxCount >= rxTrigLevel));
    txReq    = ierReg[EN_TX] & txPend;
    modemReq = ierReg[EN_MODEM] & (|msrDelta);
  end

  always_comb begin
    if (lineReq)       code = CODE_LINE;
    else if (tmoReq)   code = CODE_TMOUT;
    else if (rxGate)   code = rxReady ? CODE_RXDATA : CODE_NONE;
    else if (txReq)    code = CODE_TXRDY;
    else if (modemReq) code = CODE_MODEM;
    else               code = CODE_NONE;
  end

  assign iirValue = {{2{fifoEnable}}, 2'b00, code};
  assign irqOut   = (code != CODE_NONE);
  assign ierValue = ierReg;

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ierWrEn,
  input  logic [7:0]       ierWrData,
  input  logic             thrEmpty,
  input  logic             thrWrEn,
  input  logic             iirRdEn,
  input  logic [4:0]       lineStat,
  input  logic             rxTimeout,
  input  logic             fifoEnable,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] rxTrigLevel,
  input  logic [3:0]       msrDelta,
  output logic [7:0]       iirValue,
  output logic             irqOut,
  output logic [3:0]       ierValue
);

  ctrlStrobes_t strobe;

  uart_irq_ctrl u_ctrl (
    .ierWrEn  (ierWrEn),
    .thrEmpty (thrEmpty),
    .thrWrEn  (thrWrEn),
    .iirRdEn  (iirRdEn),
    .strobe   (strobe)
  );

  uart_irq_dp #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .ierWrData   (ierWrData),
    .lineStat    (lineStat),
    .rxTimeout   (rxTimeout),
    .fifoEnable  (fifoEnable),
    .rxCount     (rxCount),
    .rxTrigLevel (rxTrigLevel),
    .msrDelta    (msrDelta),
    .iirValue    (iirValue),
    .irqOut      (irqOut),
    .ierValue    (ierValue)
  );

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ierWrEn,
  input logic [3:0] wrLow,
  input logic       thrWrEn,
  input logic       iirRdEn,
  input logic [4:0] lineStat,
  input logic [7:0] iirValue,
  input logic       irqOut,
  input logic [3:0] ierValue
);

  // R9
  ier_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    ierWrEn |=> ierValue == $past(wrLow));

  // R10
  thr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    thrWrEn |=> iirValue[3:0] != 4'h2);

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    iirRdEn |=> iirValue[3:0] != 4'h2);

  // R3
  line_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ierValue[2] && (|lineStat[4:1])) |-> iirValue[3:0] == 4'h6);

  // R4
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ierValue[0] |-> (iirValue[3:0] != 4'hC && iirValue[3:0] != 4'h4));

  // R12
  irq_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (iirValue[3:0] != 4'h1));

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ierWrEn  (ierWrEn),
  .wrLow    (ierWrData[3:0]),
  .thrWrEn  (thrWrEn),
  .iirRdEn  (iirRdEn),
  .lineStat (lineStat),
  .iirValue (iirValue),
  .irqOut   (irqOut),
  .ierValue (ierValue)
);

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 5;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             ierWrEn = 1'b0;
  logic [7:0]       ierWrData = '0;
  logic             thrEmpty = 1'b0;
  logic             thrWrEn = 1'b0;
  logic             iirRdEn = 1'b0;
  logic [4:0]       lineStat = '0;
  logic             rxTimeout = 1'b0;
  logic             fifoEnable = 1'b0;
  logic [CNT_W-1:0] rxCount = '0;
  logic [CNT_W-1:0] rxTrigLevel = '0;
  logic [3:0]       msrDelta = '0;
  logic [7:0]       iirValue;
  logic             irqOut;
  logic [3:0]       ierValue;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ident #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .ierWrEn(ierWrEn), .ierWrData(ierWrData),
    .thrEmpty(thrEmpty), .thrWrEn(thrWrEn), .iirRdEn(iirRdEn),
    .lineStat(lineStat), .rxTimeout(rxTimeout), .fifoEnable(fifoEnable),
    .rxCount(rxCount), .rxTrigLevel(rxTrigLevel), .msrDelta(msrDelta),
    .iirValue(iirValue), .irqOut(irqOut), .ierValue(ierValue)
  );

  function automatic logic [7:0] model(input logic [3:0] en, input logic [4:0] ls,
                                       input logic tmo, input logic fe,
                                       input int cnt, input int trig,
                                       input logic pend, input logic [3:0] md);
    logic [3:0] c;
    if (en[2] && ls[4:1] != 0)      c = 4'h6;
    else if (en[0] && tmo)          c = 4'hC;
    else if (en[0] && ls[0])        c = (!fe || cnt >= trig) ? 4'h4 : 4'h1;
    else if (en[1] && pend)         c = 4'h2;
    else if (en[3] && md != 0)      c = 4'h0;
    else                            c = 4'h1;
    return {fe, fe, 2'b00, c};
  endfunction

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    tick; tick;
    rstN = 1'b1;
    #1;
    // R1 reset state
    check8("R1 iir", iirValue, 8'h01);
    check8("R1 irq", {7'd0, irqOut}, 8'h00);
    check8("R1 ier", {4'd0, ierValue}, 8'h00);

    // R9 only low nibble kept, no arm when holding register busy
    ierWrEn = 1; ierWrData = 8'hF6; thrEmpty = 0; tick; ierWrEn = 0;
    check8("R9 ier low nibble", {4'd0, ierValue}, 8'h06);
    check8("R9 no arm", iirValue, 8'h01);
    ierWrEn = 1; ierWrData = 8'h02; thrEmpty = 1; tick; ierWrEn = 0; thrEmpty = 0;
    check8("R9 arm", iirValue, 8'h02);
    check8("R12 irq high", {7'd0, irqOut}, 8'h01);

    // R8 read shows value before clear, then clears
    iirRdEn = 1; #1;
    check8("R8 read cycle value", iirValue, 8'h02);
    tick; iirRdEn = 0;
    check8("R8 cleared", iirValue, 8'h01);

    // R10 holding write clears
    ierWrEn = 1; thrEmpty = 1; tick; ierWrEn = 0; thrEmpty = 0;
    check8("R10 rearmed", iirValue, 8'h02);
    thrWrEn = 1; tick; thrWrEn = 0;
    check8("R10 cleared", iirValue, 8'h01);

    // R11 coincident arm and clear
    ierWrEn = 1; ierWrData = 8'h0A; thrEmpty = 1; iirRdEn = 1; tick;
    ierWrEn = 0; thrEmpty = 0; iirRdEn = 0;
    check8("R11 read vs arm", iirValue, 8'h01);
    check8("R11 ier stored", {4'd0, ierValue}, 8'h0A);
    ierWrEn = 1; ierWrData = 8'h02; thrEmpty = 1; thrWrEn = 1; tick;
    ierWrEn = 0; thrEmpty = 0; thrWrEn = 0;
    check8("R11 write vs arm", iirValue, 8'h01);

    // R7 fifo bits on idle
    fifoEnable = 1; #1;
    check8("R7 fifo idle", iirValue, 8'hC1);
    fifoEnable = 0;

    // Sweep R2 R3 R4 R5 R6 R7 R12
    for (int n = 0; n < 2048; n++) begin
      logic [3:0] en;
      logic errOn, dr, tmo, fe, below, pend, msOn;
      logic [4:0] ls;
      logic [3:0] md;
      logic [7:0] exp;
      int cnt;
      en = n[3:0]; errOn = n[4]; dr = n[5]; tmo = n[6];
      fe = n[7]; below = n[8]; pend = n[9]; msOn = n[10];
      iirRdEn = 1; tick; iirRdEn = 0;
      ierWrEn = 1; ierWrData = {n[7:4], en}; thrEmpty = pend; tick;
      ierWrEn = 0; thrEmpty = 0;
      ls = {4'd0, dr};
      if (errOn) ls[1 + (n % 4)] = 1'b1;
      md = msOn ? (4'd1 << ((n / 3) % 4)) : 4'd0;
      cnt = below ? 7 : ((n % 3 == 0) ? 16 : 8);
      lineStat = ls; rxTimeout = tmo; fifoEnable = fe;
      rxCount = CNT_W'(cnt); rxTrigLevel = CNT_W'(8); msrDelta = md;
      #1;
      exp = model(en, ls, tmo, fe, cnt, 8, pend, md);
      check8("R2/R3/R4/R5/R6/R7 sweep", iirValue, exp);
      check8("R12 sweep", {7'd0, irqOut}, {7'd0, exp[3:0] != 4'h1});
      lineStat = '0; rxTimeout = 0; fifoEnable = 0; msrDelta = '0;
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule